// File: doc/BRIEF.md
# Micro-op Condition Test Evaluator

This combinational block decides whether a conditional micro-operation takes effect. It reads the current flag word and a 5-bit condition-select code. It returns a one-bit verdict and an error indication. The tests it supports fall into four groups:
- single-flag tests;
- unsigned and signed compound comparisons;
- tests on two emulation-only flags, an emulation carry and an emulation zero;
- a mixed test that combines the emulation zero flag with the architectural zero flag.

Each test also exists in inverted form. Eight codes are reserved for string-operation conditions that the block does not implement. Selecting one of them raises the error output. The flags are produced elsewhere, and the verdict is consumed elsewhere by commit or branch logic.

The select code is split into two parts. The high bit inverts the result. The low four bits pick the base test. The flag word uses a fixed layout that the flag generator shares: carry at bit 0, parity at bit 2, zero at bit 6, sign at bit 7, overflow at bit 11, emulation carry at bit 16 and emulation zero at bit 17.

Top module: `cond_test_eval`

## Requirements
- R1: Code 0 always gives condMet=1 and code 16 always gives condMet=0, with condErr=0 in both cases.
- R2: The single-flag codes return the flag value directly. Code 1 is emulation carry (bit 16), code 2 is emulation zero (bit 17), code 8 is overflow (bit 11), code 9 is carry (bit 0), code 10 is zero (bit 6), code 12 is sign (bit 7) and code 13 is parity (bit 2).
- R3: Code 3 gives NOT(zero AND NOT emulation-zero).
- R4: Code 11 gives carry OR zero.
- R5: Code 14 gives sign XOR overflow, and code 15 gives (sign XOR overflow) OR zero.
- R6: For every supported base code b in 0..15, code b+16 gives the complement of code b's result for the same flag word.
- R7: Codes 4, 5, 6, 7, 20, 21, 22 and 23 are reserved. Each drives condErr=1 and condMet=1.
- R8: Every code outside the reserved set drives condErr=0.
- R9: Flag-word bits other than 0, 2, 6, 7, 11, 16 and 17 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| flagWord | input | 32 | Current flag word |
| condSel | input | 5 | Condition select: bit 4 inverts, bits 3:0 pick the base test |
| condMet | output | 1 | Condition verdict |
| condErr | output | 1 | High when a reserved code is selected |

## Verification
The hardest cases are the compound tests, because their outcome depends on combinations of two or three flags. Examples are the emulation-zero exclusion and the signed less-or-equal test. A plain walk over the codes with a few flag words would leave some of these combinations unexercised. The bench therefore sweeps every one of the 128 assignments of the seven tested flag bits against all 32 codes. It then repeats the sweep with pseudo-random values in the untested bit positions, which shows that those positions never leak into the verdict.

// File: rtl/cond_test_pkg.sv
package cond_test_pkg;

  localparam int NUM_TESTED = 7;
  localparam int IDX_CARRY  = 0;
  localparam int IDX_PARITY = 1;
  localparam int IDX_ZERO   = 2;
  localparam int IDX_SIGN   = 3;
  localparam int IDX_OVF    = 4;
  localparam int IDX_ECARRY = 5;
  localparam int IDX_EZERO  = 6;

  typedef enum logic [2:0] {
    K_CONST,  // constant one
    K_FLAG,   // single flag picked by flagSel
    K_ZEXCL,  // not (zero and not emulation-zero)
    K_ULE,    // carry or zero
    K_SLT,    // sign xor overflow
    K_SLE     // (sign xor overflow) or zero
  } testKindT;

  typedef struct packed {
    testKindT   kind;
    logic [2:0] flagSel;
    logic       invert;
    logic       reserved;
  } condStrobeT;

endpackage

// File: rtl/cond_decode.sv
module cond_decode
  import cond_test_pkg::*;
#(
  parameter int SEL_W = 5
) (
  input  logic [SEL_W-1:0] condSel,
  output condStrobeT       strobe
);
  localparam int BASE_W = SEL_W - 1;

  logic [BASE_W-1:0] baseCode;
  assign baseCode = condSel[BASE_W-1:0];

  always_comb begin
    strobe          = '0;
    strobe.kind     = K_CONST;
    strobe.invert   = condSel[SEL_W-1];
    strobe.reserved = 1'b0;
    unique case (baseCode)
      4'd0:  strobe.kind = K_CONST;
      4'd1:  begin strobe.kind = K_FLAG; strobe.flagSel = 3'(IDX_ECARRY); end
      4'd2:  begin strobe.kind = K_FLAG; strobe.flagSel = 3'(IDX_EZERO);  end
      4'd3:  strobe.kind = K_ZEXCL;
      4'd4, 4'd5, 4'd6, 4'd7: strobe.reserved = 1'b1;
      4'd8:  begin strobe.kind = K_FLAG; strobe.flagSel = 3'(IDX_OVF);    end
      4'd9:  begin strobe.kind = K_FLAG; strobe.flagSel = 3'(IDX_CARRY);  end
      4'd10: begin strobe.kind = K_FLAG; strobe.flagSel = 3'(IDX_ZERO);   end
      4'd11: strobe.kind = K_ULE;
      4'd12: begin strobe.kind = K_FLAG; strobe.flagSel = 3'(IDX_SIGN);   end
      4'd13: begin strobe.kind = K_FLAG; strobe.flagSel = 3'(IDX_PARITY); end
      4'd14: strobe.kind = K_SLT;
      default: strobe.kind = K_SLE;
    endcase
  end

  // R7: reserved strobe must never coexist with a non-constant kind
  always_comb begin
    a_r7_reserved_kind: assert (!strobe.reserved || strobe.kind == K_CONST)
      else $error("reserved code decoded to a live test kind");
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_test_pkg::*;
#(
  parameter int FLAG_W     = 32,
  parameter int CARRY_BIT  = 0,
  parameter int PARITY_BIT = 2,
  parameter int ZERO_BIT   = 6,
  parameter int SIGN_BIT   = 7,
  parameter int OVF_BIT    = 11,
  parameter int ECARRY_BIT = 16,
  parameter int EZERO_BIT  = 17
) (
  input  logic [FLAG_W-1:0] flagWord,
  input  condStrobeT        strobe,
  output logic              condMet,
  output logic              condErr
);
  localparam int POS [NUM_TESTED] = '{CARRY_BIT, PARITY_BIT, ZERO_BIT,
                                      SIGN_BIT, OVF_BIT, ECARRY_BIT, EZERO_BIT};

  logic [NUM_TESTED-1:0] picked;

  for (genvar i = 0; i < NUM_TESTED; i++) begin : g_pick
    if (POS[i] >= FLAG_W) begin : g_absent
      assign picked[i] = 1'b0;
    end else begin : g_present
      assign picked[i] = flagWord[POS[i]];
    end
  end

  logic signedLess;
  logic rawMet;

  assign signedLess = picked[IDX_SIGN] ^ picked[IDX_OVF];

  always_comb begin
    unique case (strobe.kind)
      K_CONST: rawMet = 1'b1;
      K_FLAG:  rawMet = picked[strobe.flagSel];
      K_ZEXCL: rawMet = ~(picked[IDX_ZERO] & ~picked[IDX_EZERO]);
      K_ULE:   rawMet = picked[IDX_CARRY] | picked[IDX_ZERO];
      K_SLT:   rawMet = signedLess;
      K_SLE:   rawMet = signedLess | picked[IDX_ZERO];
      default: rawMet = 1'b1;
    endcase
  end

  assign condErr = strobe.reserved;
  assign condMet = strobe.reserved ? 1'b1 : (rawMet ^ strobe.invert);

  always_comb begin
    // R7: an error verdict always reads as taken
    a_r7_err_forces_one: assert (!condErr || condMet)
      else $error("error raised with condMet low");
    // R4: a set carry makes the unsigned test true
    a_r4_carry_implies_le: assert (!(strobe.kind == K_ULE && picked[IDX_CARRY]) || rawMet)
      else $error("unsigned le false with carry set");
    // R5: equal sign and overflow with zero clear make signed le false
    a_r5_sle_false: assert (!(strobe.kind == K_SLE && !signedLess && !picked[IDX_ZERO]) || !rawMet)
      else $error("signed le true without cause");
    // R3: clear zero flag makes the exclusion test true
    a_r3_zero_clear: assert (!(strobe.kind == K_ZEXCL && !picked[IDX_ZERO]) || rawMet)
      else $error("zero exclusion false with zero clear");
  end
endmodule

// File: rtl/cond_test_eval.sv
module cond_test_eval
  import cond_test_pkg::*;
#(
  parameter int FLAG_W = 32,
  parameter int SEL_W  = 5
) (
  input  logic [FLAG_W-1:0] flagWord,
  input  logic [SEL_W-1:0]  condSel,
  output logic              condMet,
  output logic              condErr
);
  condStrobeT strobe;

  cond_decode #(.SEL_W(SEL_W)) u_decode (
    .condSel (condSel),
    .strobe  (strobe)
  );

  cond_eval #(.FLAG_W(FLAG_W)) u_eval (
    .flagWord (flagWord),
    .strobe   (strobe),
    .condMet  (condMet),
    .condErr  (condErr)
  );

  // R1: the inverted constant never reads as taken
  always_comb begin
    a_r1_never_code: assert (condSel != SEL_W'(16) || (!condMet && !condErr))
      else $error("inverted constant produced a taken verdict");
  end
endmodule

// File: tb/tb_cond_test_eval.sv
`timescale 1ns/1ps
module tb_cond_test_eval;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] flagWord = '0;
  logic [4:0]  condSel = '0;
  logic        condMet, condErr;
  int          nRun = 0, nFail = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #5 clk = ~clk;

  cond_test_eval dut (
    .flagWord (flagWord),
    .condSel  (condSel),
    .condMet  (condMet),
    .condErr  (condErr)
  );

  // behavioural reference: returns {err, met}
  function automatic logic [1:0] refModel(int code, logic [31:0] f);
    logic cf, pf, zf, sf, ovf, ec, ez, v;
    int b;
    cf = f[0]; pf = f[2]; zf = f[6]; sf = f[7]; ovf = f[11]; ec = f[16]; ez = f[17];
    b = code % 16;
    if (b >= 4 && b <= 7) return 2'b11;
    case (b)
      0: v = 1;
      1: v = ec;
      2: v = ez;
      3: v = !(zf && !ez);
      8: v = ovf;
      9: v = cf;
      10: v = zf;
      11: v = cf || zf;
      12: v = sf;
      13: v = pf;
      14: v = sf != ovf;
      default: v = (sf != ovf) || zf;
    endcase
    if (code >= 16) v = !v;
    return {1'b0, v};
  endfunction

  function automatic string reqOf(int code);
    int b = code % 16;
    if (b >= 4 && b <= 7) return "R7";
    if (code >= 16) return "R6";
    case (b)
      0: return "R1";
      3: return "R3";
      11: return "R4";
      14, 15: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s code=%0d flags=%h actual={err,met}=%b expected=%b",
               req, condSel, flagWord, act, exp);
    end
  endtask

  task automatic apply(int code, logic [31:0] f, string req);
    @(posedge clk);
    #1;
    condSel  = code[4:0];
    flagWord = f;
    @(negedge clk);
    check(req, {condErr, condMet}, refModel(code, f));
    if (refModel(code, f) == 2'b11 || !refModel(code, f)[1] || refModel(code, f)[1])
      if (!(code % 16 >= 4 && code % 16 <= 7)) check("R8", {condErr, 1'b0}, 2'b00);
  endtask

  function automatic logic [31:0] spread(int p);
    logic [31:0] f = '0;
    f[0] = p[0]; f[2] = p[1]; f[6] = p[2]; f[7] = p[3];
    f[11] = p[4]; f[16] = p[5]; f[17] = p[6];
    return f;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {condErr, condMet}, 2'b01);  // reset state: code 0, flags clear
    // full sweep of the seven tested flag bits over all codes
    for (int code = 0; code < 32; code++)
      for (int p = 0; p < 128; p++)
        apply(code, spread(p), reqOf(code));
    // R9: noise in untested bit positions
    for (int n = 0; n < 2048; n++) begin
      logic [31:0] noise;
      lfsr  = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      noise = lfsr & ~32'h0003_08C5;
      apply(n % 32, spread(n / 16) | noise, "R9");
    end
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule